// File: doc/BRIEF.md
# Skewed Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps four tables of 2-bit saturating counters. The first is a bimodal table reached through the branch address alone. The second and third are two global tables, each reached through its own hash of address and global history. The fourth is a chooser table. The three direction components vote by majority. The chooser's counter then decides whether the final guess comes from the bimodal component alone or from that vote.

A front end presents a branch address and a history value on the lookup port. Two clock cycles later the block returns the final guess together with the four component bits. The front end keeps those bits with the branch. When the branch resolves, it sends them back on the update port with the address, the history and the real outcome. Training is partial: the block writes only the tables that the rules below select. Both ports accept a new transfer on every cycle and have no ready signal. The lookup result is a single-cycle pulse that the consumer must capture, because the block cannot be held back. Global history is kept outside the block.

Top module: `bgs_predictor`

## Requirements
- R1: After reset, every direction counter holds 01 (weakly not taken) and every chooser counter holds 01 (weakly favouring the bimodal component). pred_valid is low.
- R2: pred_valid is high exactly two rising edges after the edge that sampled lk_valid high. While pred_valid is low, all prediction bits are 0.
- R3: With a = pc[IDX_W+1:2], a2 = pc[2*IDX_W+1:IDX_W+2] and h = hist[IDX_W-1:0], the table indices are:
  - bimodal = a;
  - first global = a ^ h;
  - second global = a ^ a2 ^ (h rotated left by 3);
  - chooser = a ^ (h bit-reversed).
- R4: Each component bit is the MSB of its counter, where 1 means taken. The vote is the majority of the three direction bits. pred_taken is the vote when the chooser bit is 1 and the bimodal bit when it is 0.
- R5: An update is correct when the final guess rebuilt from the stored bits equals the outcome. A correct update whose three stored direction bits all agree writes no table.
- R6: A correct update with disagreeing direction bits moves every component whose stored bit equals the outcome one step toward the outcome.
- R7: The chooser is trained only when the stored bimodal bit differs from the stored vote. It then moves one step toward 1 if the vote equals the outcome, and toward 0 otherwise. This applies on both correct and wrong updates.
- R8: On a wrong update, the final guess is recomputed using the chooser's MSB after the R7 step. If that recomputed guess equals the outcome, only the components whose stored bit equals the outcome move toward it.
- R9: On a wrong update whose recomputed guess is still wrong, all three direction counters move one step toward the outcome.
- R10: Counters saturate at 00 and 11.
- R11: A lookup read and an update write that fall on the same edge and the same entry return the counter value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Lookup branch address |
| lk_hist | input | HIST_W | Lookup global history |
| pred_valid | output | 1 | Prediction present (two cycles after request) |
| pred_taken | output | 1 | Final direction guess |
| pred_bim | output | 1 | Bimodal component bit |
| pred_g0 | output | 1 | First global component bit |
| pred_g1 | output | 1 | Second global component bit |
| pred_meta | output | 1 | Chooser bit (1 selects the vote) |
| up_valid | input | 1 | Update request this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History used at its lookup |
| up_taken | input | 1 | Actual outcome |
| up_bim | input | 1 | Stored bimodal bit |
| up_g0 | input | 1 | Stored first global bit |
| up_g1 | input | 1 | Stored second global bit |
| up_meta | input | 1 | Stored chooser bit |

## Verification
The bench targets several corner cases, and each shows a characteristic failure when handled wrongly:
- **Agreeing and correct update.** A design that trains anyway shifts a counter from 01 to 00. The next training step then leaves that branch at not-taken instead of taken.
- **Chooser recompute.** Feeding stored bits where the bimodal component is wrong and the two global components are right shows whether the recomputed guess picks the vote. A design that skips the recompute also retrains the bimodal counter.
- **Saturation.** Repeated training toward taken, followed by two not-taken updates, exposes a wrapping counter: it flips sign one step early or one step late.
- **Same-entry collision.** A lookup and an update on the same entry in the same cycle show whether the read returns the value from before the write.
- **Random stress.** Long runs mix aliased addresses, random stored bits and back-to-back traffic on both ports.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int NTBL     = 4;
  localparam int TBL_BIM  = 0;
  localparam int TBL_G0   = 1;
  localparam int TBL_G1   = 2;
  localparam int TBL_META = 3;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_LO = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'd1;
    else    r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/bgs_hash.sv
module bgs_hash #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]                     pc,
  input  logic [HIST_W-1:0]                   hist,
  output logic [bgs_pkg::NTBL-1:0][IDX_W-1:0] idx
);
  import bgs_pkg::*;
  localparam int ROT = 3;

  logic [IDX_W-1:0] a_lo, a_hi, h, h_rot, h_rev;

  assign a_lo  = pc[IDX_W+1:2];
  assign a_hi  = pc[2*IDX_W+1:IDX_W+2];
  assign h     = hist[IDX_W-1:0];
  assign h_rot = {h[IDX_W-ROT-1:0], h[IDX_W-1:IDX_W-ROT]};

  for (genvar i = 0; i < IDX_W; i++) begin : g_rev
    assign h_rev[i] = h[IDX_W-1-i];
  end

  assign idx[TBL_BIM]  = a_lo;
  assign idx[TBL_G0]   = a_lo ^ h;
  assign idx[TBL_G1]   = a_lo ^ a_hi ^ h_rot;
  assign idx[TBL_META] = a_lo ^ h_rev;
endmodule

// File: rtl/bgs_ctr_bank.sv
module bgs_ctr_bank #(
  parameter int          IDX_W = 10,
  parameter logic [1:0]  INIT  = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_q,
  input  logic [IDX_W-1:0] up_idx,
  output logic [1:0]       up_cur,
  input  logic             we,
  input  logic [1:0]       wdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] mem [DEPTH];

  assign up_cur = mem[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_q <= INIT;
    end else begin
      rd_q <= mem[rd_idx];
      if (we) mem[up_idx] <= wdata;
    end
  end
endmodule

// File: rtl/bgs_train.sv
module bgs_train (
  input  logic                              up_valid,
  input  logic                              up_taken,
  input  logic                              st_bim,
  input  logic                              st_g0,
  input  logic                              st_g1,
  input  logic                              st_meta,
  input  logic [bgs_pkg::NTBL-1:0][1:0]     cur,
  output logic [bgs_pkg::NTBL-1:0]          we,
  output logic [bgs_pkg::NTBL-1:0][1:0]     wdata
);
  import bgs_pkg::*;

  logic       vote, final_g, hit, agree, meta_tr, m_now, final2;
  logic [2:0] comp;
  ctr_t       meta_new;

  always_comb begin
    comp     = {st_g1, st_g0, st_bim};
    vote     = maj3(st_bim, st_g0, st_g1);
    final_g  = st_meta ? vote : st_bim;
    hit      = (final_g == up_taken);
    agree    = (st_bim == st_g0) && (st_g0 == st_g1);
    meta_tr  = (st_bim != vote);
    meta_new = ctr_step(cur[TBL_META], vote == up_taken);
    m_now    = meta_tr ? meta_new[1] : cur[TBL_META][1];
    final2   = m_now ? vote : st_bim;
    for (int i = 0; i < 3; i++) begin
      wdata[i] = ctr_step(cur[i], up_taken);
      if (hit)                     we[i] = up_valid && !agree && (comp[i] == up_taken);
      else if (final2 == up_taken) we[i] = up_valid && (comp[i] == up_taken);
      else                         we[i] = up_valid;
    end
    we[TBL_META]    = up_valid && meta_tr;
    wdata[TBL_META] = meta_new;
  end
endmodule

// File: rtl/bgs_predictor.sv
module bgs_predictor #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [HIST_W-1:0] lk_hist,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_bim,
  output logic              pred_g0,
  output logic              pred_g1,
  output logic              pred_meta,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken,
  input  logic              up_bim,
  input  logic              up_g0,
  input  logic              up_g1,
  input  logic              up_meta
);
  import bgs_pkg::*;

  logic [NTBL-1:0][IDX_W-1:0] lk_idx, up_idx, s1_idx;
  logic [NTBL-1:0][1:0]       rd_q, up_cur, wdata;
  logic [NTBL-1:0]            we;
  logic                       s1_valid, s2_valid;
  logic                       vote;

  bgs_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_lk_hash (
    .pc(lk_pc), .hist(lk_hist), .idx(lk_idx));

  bgs_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_up_hash (
    .pc(up_pc), .hist(up_hist), .idx(up_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s2_valid <= 1'b0;
    end else begin
      s1_valid <= lk_valid;
      s1_idx   <= lk_idx;
      s2_valid <= s1_valid;
    end
  end

  for (genvar t = 0; t < NTBL; t++) begin : g_bank
    bgs_ctr_bank #(.IDX_W(IDX_W), .INIT(CTR_WEAK_LO)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(s1_idx[t]), .rd_q(rd_q[t]),
      .up_idx(up_idx[t]), .up_cur(up_cur[t]),
      .we(we[t]), .wdata(wdata[t]));
  end

  bgs_train u_train (
    .up_valid(up_valid), .up_taken(up_taken),
    .st_bim(up_bim), .st_g0(up_g0), .st_g1(up_g1), .st_meta(up_meta),
    .cur(up_cur), .we(we), .wdata(wdata));

  assign vote       = maj3(rd_q[TBL_BIM][1], rd_q[TBL_G0][1], rd_q[TBL_G1][1]);
  assign pred_valid = s2_valid;
  assign pred_bim   = s2_valid & rd_q[TBL_BIM][1];
  assign pred_g0    = s2_valid & rd_q[TBL_G0][1];
  assign pred_g1    = s2_valid & rd_q[TBL_G1][1];
  assign pred_meta  = s2_valid & rd_q[TBL_META][1];
  assign pred_taken = s2_valid & (rd_q[TBL_META][1] ? vote : rd_q[TBL_BIM][1]);
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic pred_valid,
  input logic pred_taken,
  input logic pred_bim,
  input logic pred_g0,
  input logic pred_g1,
  input logic pred_meta
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (pred_valid == $past(lk_valid, 2))); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> !(pred_taken | pred_bim | pred_g0 | pred_g1 | pred_meta)); // R2

  AST_AGREE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_bim == pred_g0 && pred_g0 == pred_g1) |-> (pred_taken == pred_bim)); // R4

  AST_FINAL_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_meta) |-> (pred_taken == pred_bim)); // R4
endmodule

bind bgs_predictor bgs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
  .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_bim(pred_bim),
  .pred_g0(pred_g0), .pred_g1(pred_g1), .pred_meta(pred_meta));

// File: tb/sim_bgs_predictor.sv
`timescale 1ns/1ps
module sim_bgs_predictor;
  localparam int PC_W = 32, HIST_W = 12, IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0; logic [PC_W-1:0] lk_pc = '0; logic [HIST_W-1:0] lk_hist = '0;
  logic pred_valid, pred_taken, pred_bim, pred_g0, pred_g1, pred_meta;
  logic up_valid = 1'b0; logic [PC_W-1:0] up_pc = '0; logic [HIST_W-1:0] up_hist = '0;
  logic up_taken = 1'b0, up_bim = 1'b0, up_g0 = 1'b0, up_g1 = 1'b0, up_meta = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  bgs_predictor #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u0 (.*);

  // Behavioural reference model
  int mdl [4][DEPTH];
  int s1v, s2v;
  int s1i [4];
  int s2c [4];

  function automatic int hidx(int tb, logic [PC_W-1:0] pc, logic [HIST_W-1:0] hs);
    int a, a2, h, rot, rev;
    a = (pc >> 2) % DEPTH;
    a2 = (pc >> (IDX_W + 2)) % DEPTH;
    h = hs % DEPTH;
    rot = ((h << 3) | (h >> (IDX_W - 3))) % DEPTH;
    rev = 0;
    for (int i = 0; i < IDX_W; i++) if (h[i]) rev |= 1 << (IDX_W - 1 - i);
    case (tb)
      0: return a;
      1: return a ^ h;
      2: return a ^ a2 ^ rot;
      default: return a ^ rev;
    endcase
  endfunction

  function automatic int mv(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 4; t++) for (int i = 0; i < DEPTH; i++) mdl[t][i] = 1;
      s1v = 0; s2v = 0;
      for (int t = 0; t < 4; t++) begin s1i[t] = 0; s2c[t] = 1; end
    end else begin
      s2v = s1v;
      for (int t = 0; t < 4; t++) s2c[t] = mdl[t][s1i[t]];
      s1v = lk_valid;
      for (int t = 0; t < 4; t++) s1i[t] = hidx(t, lk_pc, lk_hist);
      if (up_valid) begin
        bit st [3];
        bit vt, fin, ok, agr, mtr, mnow, fin2, wr;
        int ix [4];
        st[0] = up_bim; st[1] = up_g0; st[2] = up_g1;
        for (int t = 0; t < 4; t++) ix[t] = hidx(t, up_pc, up_hist);
        vt = (int'(st[0]) + int'(st[1]) + int'(st[2])) >= 2;
        fin = up_meta ? vt : st[0];
        ok = (fin == up_taken);
        agr = (st[0] == st[1]) && (st[1] == st[2]);
        mtr = (st[0] != vt);
        if (mtr) mdl[3][ix[3]] = mv(mdl[3][ix[3]], vt == up_taken);
        mnow = mdl[3][ix[3]] >= 2;
        fin2 = mnow ? vt : st[0];
        for (int k = 0; k < 3; k++) begin
          if (ok) wr = !agr && (st[k] == up_taken);
          else if (fin2 == up_taken) wr = (st[k] == up_taken);
          else wr = 1;
          if (wr) mdl[k][ix[k]] = mv(mdl[k][ix[k]], up_taken);
        end
      end
    end
  end

  task automatic chk(string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit b, g0, g1, m, vt;
    b  = s2v && s2c[0] >= 2;
    g0 = s2v && s2c[1] >= 2;
    g1 = s2v && s2c[2] >= 2;
    m  = s2v && s2c[3] >= 2;
    vt = (int'(b) + int'(g0) + int'(g1)) >= 2;
    chk("R2 pred_valid", pred_valid, s2v != 0);
    chk("R3 pred_bim", pred_bim, b);
    chk("R3 pred_g0", pred_g0, g0);
    chk("R3 pred_g1", pred_g1, g1);
    chk("R4 pred_meta", pred_meta, m);
    chk("R4 pred_taken", pred_taken, s2v != 0 && (m ? vt : b));
  end

  task automatic lookup(logic [PC_W-1:0] pc, logic [HIST_W-1:0] h);
    @(negedge clk); lk_valid = 1; lk_pc = pc; lk_hist = h;
    @(negedge clk); lk_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic update(logic [PC_W-1:0] pc, logic [HIST_W-1:0] h, bit t,
                        bit b, bit g0, bit g1, bit m);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_hist = h; up_taken = t;
    up_bim = b; up_g0 = g0; up_g1 = g1; up_meta = m;
    @(negedge clk); up_valid = 0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; lookup(32'h0000_1000, 12'h0a5); lookup(32'h0003_4564, 12'h3ff);
    tag = "R5"; update(32'h100, 12'h011, 0, 0, 0, 0, 0); update(32'h100, 12'h011, 0, 0, 0, 0, 0);
    update(32'h100, 12'h011, 1, 1, 0, 0, 0); lookup(32'h100, 12'h011);
    tag = "R6"; update(32'h200, 12'h022, 1, 1, 0, 0, 0); lookup(32'h200, 12'h022);
    tag = "R7"; update(32'h300, 12'h033, 1, 0, 1, 1, 0); lookup(32'h300, 12'h033);
    tag = "R8"; update(32'h300, 12'h033, 1, 0, 1, 1, 0); lookup(32'h300, 12'h033);
    tag = "R9"; update(32'h400, 12'h044, 1, 0, 0, 0, 0); lookup(32'h400, 12'h044);
    tag = "R10";
    for (int i = 0; i < 5; i++) update(32'h500, 12'h055, 1, 0, 0, 0, 0);
    lookup(32'h500, 12'h055);
    update(32'h500, 12'h055, 0, 1, 1, 1, 1); lookup(32'h500, 12'h055);
    update(32'h500, 12'h055, 0, 1, 1, 1, 1); lookup(32'h500, 12'h055);
    tag = "R11";
    @(negedge clk); lk_valid = 1; lk_pc = 32'h600; lk_hist = 12'h066;
    @(negedge clk); lk_valid = 0;
    up_valid = 1; up_pc = 32'h600; up_hist = 12'h066; up_taken = 1;
    up_bim = 0; up_g0 = 0; up_g1 = 0; up_meta = 0;
    @(negedge clk); up_valid = 0;
    repeat (2) @(negedge clk);
    lookup(32'h600, 12'h066);
    tag = "R4";
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      lk_valid = ($urandom % 4) != 0;
      lk_pc = {20'h0, 4'($urandom % 16), 8'h0} | 32'($urandom % 4) << 2;
      lk_hist = 12'($urandom % 8);
      up_valid = ($urandom % 3) != 0;
      up_pc = {20'h0, 4'($urandom % 16), 8'h0} | 32'($urandom % 4) << 2;
      up_hist = 12'($urandom % 8);
      up_taken = 1'($urandom); up_bim = 1'($urandom); up_g0 = 1'($urandom);
      up_g1 = 1'($urandom); up_meta = 1'($urandom);
    end
    @(negedge clk); lk_valid = 0; up_valid = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule